// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Error-Tagged Receive Buffer

The block turns an asynchronous serial line into parallel characters. A single-cycle sampling enable arrives at sixteen times the bit rate. The receiver uses it to find the falling edge of a start bit and confirms that start bit halfway through the bit. It then samples each later bit at its centre.

Character length can be 5 to 8 bits, and parity can be none, even or odd. Every completed character goes into a receive buffer together with three flags: parity error, framing error and line break. The buffer holds 16 entries in buffered mode and one entry in single-character mode. The reader sees the oldest entry on the output pins and removes it with a pop strobe.

A sticky overrun flag records that a character arrived while the buffer was full. Two outputs report buffer state: a data-ready flag and a receive-ready flag for a DMA engine. A loopback select takes the receiver input from a local transmitter output instead of the external pin.

Top module: `serial_rx_unit`

## Requirements
- R1: `cfg_len` selects the character length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant bit first, and unused upper bits of `rd_data` read as 0.
- R2: With `cfg_par_en`=1, one parity bit follows the data bits. `rd_perr` is set when the XOR of the data bits and the parity bit differs from `cfg_par_odd` (0 means even parity, 1 means odd). With `cfg_par_en`=0, no parity bit is expected and `rd_perr` is 0.
- R3: A stop bit sampled low on a frame that is not a break stores the received data with `rd_ferr`=1.
- R4: The receiver confirms a start bit on the 8th sampling enable after it detects the low level. If the line is high at that sample, the receiver returns to idle and stores nothing.
- R5: A break is a line held low through the start bit, all data bits, the parity bit (if enabled) and the stop bit. It stores exactly one entry with data 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. No further character is assembled until the line has returned high.
- R6: In buffered mode (`fifo_en`=1), up to 16 entries are kept in arrival order. The oldest entry is shown on `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk`, and `rd_en` removes it.
- R7: A character that completes while the buffer is full is discarded. `overrun` is set and stays set until a `stat_rd` pulse; a new overrun in the same cycle as `stat_rd` wins.
- R8: With `fifo_en`=0, the buffer holds one entry. Any change of `fifo_en` empties the buffer.
- R9: `data_ready` is 1 whenever the buffer is not empty. `rx_ready` is 1 when the buffer holds at least 4 entries in buffered mode, or at least 1 entry in single-character mode.
- R10: With `loop_en`=1, the receiver takes its input from `loop_txd` and ignores `rx_serial`.
- R11: Receiver timing advances only on cycles where `tick16` is 1.
- R12: After reset, the buffer is empty, `overrun` is 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sampling enable at 16x bit rate |
| rx_serial | input | 1 | External serial line, idle high |
| loop_en | input | 1 | Selects loopback input |
| loop_txd | input | 1 | Local transmitter output, used in loopback |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| fifo_en | input | 1 | Buffered mode (16 entries) when 1 |
| rd_en | input | 1 | Pop the oldest entry |
| stat_rd | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest entry data |
| rd_perr | output | 1 | Oldest entry parity error |
| rd_ferr | output | 1 | Oldest entry framing error |
| rd_brk | output | 1 | Oldest entry break flag |
| data_ready | output | 1 | Buffer not empty |
| rx_ready | output | 1 | DMA receive-ready level |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sweeps every character length against every parity mode, using patterns that exercise all-zero and all-one characters. A wrong bit index or a bad length mask would show up as shifted or extra data bits. It sends a deliberately wrong parity bit, and separately a low stop bit followed by a low remainder of stop. A framer that resynchronised badly would store a phantom character after the framing error. It also sends a short low glitch, which an unconfirmed start detector would turn into a character, and a sustained break, which would produce repeated zero entries if the receiver did not wait for the line to go high. Finally, it fills the buffer past 16 entries and one entry in single-character mode, where an off-by-one full test would overwrite the oldest entry or miss the overrun.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAITHI
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_serial,
  input  logic loop_en,
  input  logic loop_txd,
  output logic line_o
);
  logic [STAGES-1:0] sh;
  logic              src;

  assign src = loop_en ? loop_txd : rx_serial;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], src};
  end

  assign line_o = sh[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      line,
  input  logic [1:0] cfg_len,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      push_o,
  output rx_entry_t ent_o
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(CHAR_W);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [BW-1:0]     last_idx;
  logic [CHAR_W-1:0] sr;
  logic              pbit;
  logic              allz;
  logic              mid;

  assign last_idx = BW'(cfg_len) + BW'(CHAR_W - 4);
  assign mid      = (cnt == CW'(OSR - 1));

  always_ff @(posedge clk) begin
    push_o <= 1'b0;
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      sr    <= '0;
      pbit  <= 1'b0;
      allz  <= 1'b0;
      ent_o <= '0;
    end else if (tick) begin
      case (st)
        S_IDLE: begin
          if (!line) begin
            st  <= S_START;
            cnt <= '0;
          end
        end
        S_START: begin
          if (cnt == CW'(HALF - 1)) begin
            if (line) st <= S_IDLE;
            else begin
              st   <= S_DATA;
              cnt  <= '0;
              bidx <= '0;
              sr   <= '0;
              allz <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (mid) begin
            cnt      <= '0;
            sr[bidx] <= line;
            if (line) allz <= 1'b0;
            if (bidx == last_idx) st <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (mid) begin
            cnt  <= '0;
            pbit <= line;
            if (line) allz <= 1'b0;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (mid) begin
            cnt    <= '0;
            push_o <= 1'b1;
            if (allz && !line) begin
              ent_o.brk  <= 1'b1;
              ent_o.ferr <= 1'b1;
              ent_o.perr <= 1'b0;
              ent_o.data <= '0;
              st         <= S_WAITHI;
            end else begin
              ent_o.brk  <= 1'b0;
              ent_o.ferr <= !line;
              ent_o.perr <= par_en && ((^sr ^ pbit) != par_odd);
              ent_o.data <= sr;
              st         <= S_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_WAITHI: begin
          if (line) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  false_start_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && tick && cnt == CW'(HALF - 1) && line) |=> (st == S_IDLE && !push_o));

  // R5
  break_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (push_o && ent_o.brk) |-> (ent_o.data == '0 && ent_o.ferr && !ent_o.perr));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick) |=> ($stable(cnt) && $stable(st)));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int RDY_LEVEL = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fifo_en,
  input  logic      push_i,
  input  rx_entry_t din,
  input  logic      pop_i,
  input  logic      stat_rd,
  output rx_entry_t head_o,
  output logic      not_empty_o,
  output logic      ready_o,
  output logic      ovr_o
);
  localparam int AW = $clog2(DEPTH);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic [AW:0]   cap;
  logic          full, empty, do_push, do_pop, mode_q, flush;

  assign cap     = fifo_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign flush   = (fifo_en != mode_q);
  assign do_push = push_i && !full && !flush;
  assign do_pop  = pop_i && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      ovr_o  <= 1'b0;
      mode_q <= fifo_en;
    end else begin
      mode_q <= fifo_en;
      if (flush) begin
        wp    <= '0;
        rp    <= '0;
        count <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
      if (push_i && full) ovr_o <= 1'b1;
      else if (stat_rd)   ovr_o <= 1'b0;
    end
  end

  assign head_o      = mem[rp];
  assign not_empty_o = !empty;
  assign ready_o     = fifo_en ? (count >= (AW+1)'(RDY_LEVEL)) : !empty;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && full && !pop_i && !flush) |=> (count == $past(count)));

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && full) |=> ovr_o);

  // R8
  single_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !mode_q) |-> (count <= (AW+1)'(1)));
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 16,
  parameter int RDY_LEVEL   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_serial,
  input  logic              loop_en,
  input  logic              loop_txd,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              fifo_en,
  input  logic              rd_en,
  input  logic              stat_rd,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_brk,
  output logic              data_ready,
  output logic              rx_ready,
  output logic              overrun
);
  logic      line;
  logic      push;
  rx_entry_t ent;
  rx_entry_t head;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_serial(rx_serial), .loop_en(loop_en),
    .loop_txd(loop_txd), .line_o(line)
  );

  rx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst(rst), .tick(tick16), .line(line), .cfg_len(cfg_len),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .push_o(push), .ent_o(ent)
  );

  rx_fifo #(.DEPTH(DEPTH), .RDY_LEVEL(RDY_LEVEL)) u_fifo (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .push_i(push), .din(ent),
    .pop_i(rd_en), .stat_rd(stat_rd), .head_o(head), .not_empty_o(data_ready),
    .ready_o(rx_ready), .ovr_o(overrun)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;

  // R9
  ready_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(push));
endmodule

// File: tb/sim_serial_rx_unit.sv
`timescale 1ns/1ps
module sim_serial_rx_unit;
  logic clk = 0, rst = 1, tick16 = 0;
  logic rxs = 1, loop_en = 0, ltx = 1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, fifo_en = 1, rd_en = 0, stat_rd = 0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, data_ready, rx_ready, overrun;
  int tests = 0, fails = 0, div = 1, tcnt = 0;
  bit use_loop = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= div - 1) begin tcnt <= 0; tick16 <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick16 <= 1'b0; end
  end

  serial_rx_unit u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_serial(rxs), .loop_en(loop_en),
    .loop_txd(ltx), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .fifo_en(fifo_en), .rd_en(rd_en), .stat_rd(stat_rd),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .data_ready(data_ready), .rx_ready(rx_ready), .overrun(overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    if (use_loop) ltx = b; else rxs = b;
  endtask

  task automatic hold_bits(input logic b, input int nbits);
    drive(b);
    repeat (16 * nbits * div) @(negedge clk);
  endtask

  function automatic logic [7:0] lmask(input logic [1:0] len);
    return 8'hFF >> (3 - len);
  endfunction

  task automatic send_char(input logic [7:0] d, input bit bad_par, input logic stop_v);
    logic [7:0] m;
    m = d & lmask(cfg_len);
    hold_bits(1'b0, 1);
    for (int i = 0; i < 5 + cfg_len; i++) hold_bits(m[i], 1);
    if (cfg_par_en) hold_bits((^m) ^ cfg_par_odd ^ bad_par, 1);
    hold_bits(stop_v, 1);
    hold_bits(1'b1, 1);
  endtask

  task automatic pop_check(input logic [10:0] exp, input string tag);
    logic [10:0] act;
    act = {rd_brk, rd_ferr, rd_perr, rd_data};
    check(data_ready && act == exp, tag, {data_ready, act}, {1'b1, exp});
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic pulse_stat;
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] vals [4];
    logic [7:0] e;
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'h3C;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!data_ready && !rx_ready && !overrun, "R12 reset",
          {data_ready, rx_ready, overrun}, 0);

    // R1 R2 sweep of length x parity x pattern
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++)
        for (int v = 0; v < 4; v++) begin
          cfg_len = 2'(l); cfg_par_en = (p != 0); cfg_par_odd = (p == 2);
          send_char(vals[v], 0, 1'b1);
          e = vals[v] & lmask(2'(l));
          pop_check({3'b000, e}, "R1/R2 sweep");
        end

    // R2 wrong parity, even and odd
    cfg_len = 3; cfg_par_en = 1; cfg_par_odd = 0;
    send_char(8'h5A, 1, 1'b1);
    pop_check({3'b001, 8'h5A}, "R2 even parity error");
    cfg_par_odd = 1;
    send_char(8'h5B, 1, 1'b1);
    pop_check({3'b001, 8'h5B}, "R2 odd parity error");

    // R3 framing error, low stop then idle: one entry only
    cfg_par_en = 0;
    send_char(8'h81, 0, 1'b0);
    hold_bits(1'b1, 2);
    pop_check({3'b010, 8'h81}, "R3 framing error");
    check(!data_ready, "R3 no phantom after framing", data_ready, 0);

    // R4 false start glitch
    drive(1'b0);
    repeat (4 * div) @(negedge clk);
    hold_bits(1'b1, 3);
    check(!data_ready, "R4 false start dropped", data_ready, 0);
    send_char(8'h6E, 0, 1'b1);
    pop_check({3'b000, 8'h6E}, "R4 good char after glitch");

    // R5 break held for three frames
    cfg_par_en = 1; cfg_par_odd = 0;
    hold_bits(1'b0, 33);
    hold_bits(1'b1, 2);
    pop_check({3'b110, 8'h00}, "R5 break entry");
    check(!data_ready, "R5 single break entry", data_ready, 0);

    // R9 ready level in buffered mode
    cfg_par_en = 0;
    for (int i = 0; i < 3; i++) send_char(8'(i + 16), 0, 1'b1);
    check(data_ready && !rx_ready, "R9 below level", {data_ready, rx_ready}, 2);
    send_char(8'h13, 0, 1'b1);
    check(rx_ready, "R9 at level", rx_ready, 1);
    for (int i = 0; i < 3; i++) pop_check({3'b000, 8'(i + 16)}, "R9 drain");
    pop_check({3'b000, 8'h13}, "R9 drain last");

    // R6 R7 fill beyond depth
    for (int i = 0; i < 16; i++) send_char(8'(i * 7 + 1), 0, 1'b1);
    check(!overrun, "R7 no overrun at 16", overrun, 0);
    send_char(8'hEE, 0, 1'b1);
    check(overrun, "R7 overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) pop_check({3'b000, 8'(i * 7 + 1)}, "R6 order");
    check(!data_ready, "R7 extra char discarded", data_ready, 0);
    check(overrun, "R7 overrun sticky", overrun, 1);
    pulse_stat;
    check(!overrun, "R7 cleared by status read", overrun, 0);

    // R8 single-character mode
    fifo_en = 0;
    repeat (2) @(negedge clk);
    send_char(8'h42, 0, 1'b1);
    check(rx_ready && !overrun, "R8 one held, R9 ready", {rx_ready, overrun}, 2);
    send_char(8'h43, 0, 1'b1);
    check(overrun, "R8 second char overruns", overrun, 1);
    pop_check({3'b000, 8'h42}, "R8 first kept");
    check(!data_ready, "R8 depth one", data_ready, 0);
    pulse_stat;
    send_char(8'h44, 0, 1'b1);
    fifo_en = 1;
    repeat (2) @(negedge clk);
    check(!data_ready, "R8 mode change empties", data_ready, 0);

    // R10 loopback ignores external pin held low
    rxs = 0; use_loop = 1; loop_en = 1;
    repeat (4) @(negedge clk);
    send_char(8'hC3, 0, 1'b1);
    pop_check({3'b000, 8'hC3}, "R10 loopback char");
    hold_bits(1'b1, 2);
    check(!data_ready, "R10 external pin ignored", data_ready, 0);
    rxs = 1;
    repeat (4) @(negedge clk);
    loop_en = 0; use_loop = 0;
    repeat (4) @(negedge clk);

    // R11 sparse sampling enable
    div = 3;
    hold_bits(1'b1, 1);
    cfg_par_en = 1; cfg_par_odd = 1;
    send_char(8'h96, 0, 1'b1);
    pop_check({3'b000, 8'h96}, "R11 sparse tick");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule